// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block issues single register accesses to an Ethernet PHY over a two-wire management link: a master-driven clock line and a shared data line. The data line appears as three separate signals (drive value, drive enable, sampled input), so the pad or the chip top completes the bidirectional connection. A client presents one request: a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The master then serialises a complete frame, and at the end it raises a one-cycle completion strobe. For reads, it also presents the 16 bits returned by the PHY.

The management clock is derived from the system clock. Every bit time has three equal phases (clock low, clock high, clock low). Each phase lasts `CLK_DIV` system cycles, so one bit takes `3*CLK_DIV` cycles. A frame starts with a 34-bit run of ones. The start pattern and opcode follow, then both addresses. Writes continue with a driven two-bit turnaround and the data word. Reads give up the line for one bit time and then sample 16 bits during the clock-high phase.

The controller is a seven-state machine. From `ST_IDLE`, an accepted request moves it to `ST_PREAMBLE`. After the last preamble bit it moves to `ST_HEADER`. After the 14 header bits it goes to `ST_WR_TAIL` for a write or `ST_RD_TURN` for a read. `ST_RD_TURN` moves to `ST_RD_DATA` after one bit. `ST_WR_TAIL` (18 bits) and `ST_RD_DATA` (16 bits) both end in `ST_DONE`, which lasts one cycle and returns to `ST_IDLE`.

Top module: `mgmt_frame_master`

## Requirements
- R1: Every frame begins with 34 driven bit times whose data value is 1.
- R2: The 34 ones are followed by the start bits 0,1 and then the opcode: 1,0 for a read, 0,1 for a write.
- R3: After the opcode come the 5-bit PHY address and then the 5-bit register address, each sent most significant bit first.
- R4: A write ends with driven turnaround bits 1,0 and then the 16 write-data bits, most significant first, for 66 bit times in total.
- R5: A read ends with one undriven bit time and then 16 bit times. In each of these, the data input is sampled in the clock-high phase and shifted in most significant first. The frame is 65 bit times, and `rd_data_o` holds the word once `done_o` rises.
- R6: Each bit time is `CLK_DIV` cycles of clock low, then `CLK_DIV` high, then `CLK_DIV` low. The drive value does not change within a bit time, and `busy_o` is high for exactly bit times × `3*CLK_DIV` cycles.
- R7: `mdio_oe_o` is high for the preamble, header and write tail. It is low from the read turnaround to the end of the frame and whenever the block is idle. The clock line is low when idle.
- R8: `done_o` is high for exactly one cycle, in the cycle right after the last bit time ends, with `busy_o` already low.
- R9: A request is accepted only in `ST_IDLE`. A request raised during a frame changes neither the frame in progress nor anything afterwards.
- R10: After reset, `busy_o`, `done_o`, `mdc_o`, `mdio_oe_o` and `rd_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, taken only when idle |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_phy_i | input | 5 | Target PHY address |
| req_reg_i | input | 5 | Target register address |
| req_wdata_i | input | 16 | Data for a write |
| busy_o | output | 1 | High while bit times are being produced |
| done_o | output | 1 | One-cycle completion strobe |
| rd_data_o | output | 16 | Word returned by a read |
| mdc_o | output | 1 | Management clock line |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe_o | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line sampled value |

## Verification
The bench builds the block with `CLK_DIV = 2`. At that value each clock phase spans two system cycles, so the bench can see the gap between phase boundaries and the sampling edge while frames stay near 400 cycles. With that short frame time it can sweep every PHY address and every register address in both directions, 64 frames in total. In each write, the data and turnaround bits are compared against an arithmetic pattern, and in each read a bench-side PHY model returns a computed word.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_WR_TAIL,
        ST_RD_TURN,
        ST_RD_DATA,
        ST_DONE
    } mfm_state_e;

    localparam logic [1:0] SYNC_PAT  = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] WR_TURN   = 2'b10;

endpackage

// File: rtl/mfm_phase_gen.sv
module mfm_phase_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sample_tick_o,
    output logic bit_tick_o,
    output logic mdc_o
);

    logic [1:0] phase_q;
    logic       div_last;

    generate
        if (CLK_DIV == 1) begin : g_nodiv
            assign div_last = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(CLK_DIV);
            logic [DW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run_i || div_last) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign div_last = (cnt_q == DW'(CLK_DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 2'd0;
        end else if (!run_i) begin
            phase_q <= 2'd0;
        end else if (div_last) begin
            phase_q <= (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
        end
    end

    assign sample_tick_o = run_i && (phase_q == 2'd1) && div_last;
    assign bit_tick_o    = run_i && (phase_q == 2'd2) && div_last;
    assign mdc_o         = (phase_q == 2'd1);

endmodule

// File: rtl/mfm_frame_fsm.sv
module mfm_frame_fsm
    import mfm_pkg::*;
#(
    parameter int PRE_BITS = 34,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_phy_i,
    input  logic [ADDR_W-1:0] req_reg_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              sample_tick_i,
    input  logic              bit_tick_i,
    input  logic              mdio_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              mdio_o,
    output logic              mdio_oe_o
);

    localparam int HDR_BITS  = 4 + 2 * ADDR_W;
    localparam int TAIL_BITS = 2 + DATA_W;
    localparam int TX_W      = HDR_BITS + TAIL_BITS;
    localparam int MAX_A     = (PRE_BITS > HDR_BITS) ? PRE_BITS : HDR_BITS;
    localparam int MAX_BITS  = (MAX_A > TAIL_BITS) ? MAX_A : TAIL_BITS;
    localparam int CNT_W     = $clog2(MAX_BITS + 1);

    mfm_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [TX_W-1:0]   tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic              wr_q;
    logic              last_bit;

    function automatic logic [CNT_W-1:0] span_of(input mfm_state_e s);
        logic [CNT_W-1:0] n;
        case (s)
            ST_HEADER:  n = CNT_W'(HDR_BITS - 1);
            ST_WR_TAIL: n = CNT_W'(TAIL_BITS - 1);
            ST_RD_DATA: n = CNT_W'(DATA_W - 1);
            default:    n = '0;
        endcase
        return n;
    endfunction

    assign last_bit = (cnt_q == '0);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_i) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (bit_tick_i && last_bit) state_d = ST_HEADER;
            ST_HEADER:   if (bit_tick_i && last_bit)
                             state_d = wr_q ? ST_WR_TAIL : ST_RD_TURN;
            ST_WR_TAIL:  if (bit_tick_i && last_bit) state_d = ST_DONE;
            ST_RD_TURN:  if (bit_tick_i) state_d = ST_RD_DATA;
            ST_RD_DATA:  if (bit_tick_i && last_bit) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // bit counter, shift registers and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            wr_q    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                if (req_i) begin
                    wr_q    <= req_write_i;
                    cnt_q   <= CNT_W'(PRE_BITS - 1);
                    tx_sh_q <= {SYNC_PAT, (req_write_i ? OPC_WRITE : OPC_READ),
                                req_phy_i, req_reg_i, WR_TURN, req_wdata_i};
                end
            end else if (bit_tick_i) begin
                cnt_q <= (state_d != state_q) ? span_of(state_d) : cnt_q - 1'b1;
                if (state_q == ST_HEADER || state_q == ST_WR_TAIL) begin
                    tx_sh_q <= {tx_sh_q[TX_W-2:0], 1'b0};
                end
            end
            if (state_q == ST_RD_DATA && sample_tick_i) begin
                rx_sh_q <= {rx_sh_q[DATA_W-2:0], mdio_i};
            end
        end
    end

    // outputs
    always_comb begin
        busy_o    = 1'b0;
        done_o    = 1'b0;
        mdio_o    = 1'b0;
        mdio_oe_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PREAMBLE: begin
                busy_o    = 1'b1;
                mdio_o    = 1'b1;
                mdio_oe_o = 1'b1;
            end
            ST_HEADER, ST_WR_TAIL: begin
                busy_o    = 1'b1;
                mdio_o    = tx_sh_q[TX_W-1];
                mdio_oe_o = 1'b1;
            end
            ST_RD_TURN, ST_RD_DATA: busy_o = 1'b1;
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assign rd_data_o = rx_sh_q;

    // R6
    mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$past(bit_tick_i)) |-> $stable(mdio_o));

    // R7
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mdio_oe_o) && busy_o) |-> !wr_q);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(wr_q));

endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master #(
    parameter int CLK_DIV  = 4,
    parameter int PRE_BITS = 34,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_phy_i,
    input  logic [ADDR_W-1:0] req_reg_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);

    logic sample_tick;
    logic bit_tick;

    mfm_phase_gen #(
        .CLK_DIV(CLK_DIV)
    ) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (busy_o),
        .sample_tick_o(sample_tick),
        .bit_tick_o   (bit_tick),
        .mdc_o        (mdc_o)
    );

    mfm_frame_fsm #(
        .PRE_BITS(PRE_BITS),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .req_write_i  (req_write_i),
        .req_phy_i    (req_phy_i),
        .req_reg_i    (req_reg_i),
        .req_wdata_i  (req_wdata_i),
        .sample_tick_i(sample_tick),
        .bit_tick_i   (bit_tick),
        .mdio_i       (mdio_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .rd_data_o    (rd_data_o),
        .mdio_o       (mdio_o),
        .mdio_oe_o    (mdio_oe_o)
    );

    // R7
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc_o |-> busy_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

endmodule

// File: tb/mgmt_frame_master_bench.sv
module mgmt_frame_master_bench;

    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [4:0]  req_phy_i = '0;
    logic [4:0]  req_reg_i = '0;
    logic [15:0] req_wdata_i = '0;
    logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
    logic [15:0] rd_data_o;
    logic        mdio_i = 1'b1;

    mgmt_frame_master #(.CLK_DIV(DIV)) u_mgmt_frame_master (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_write_i(req_write_i),
        .req_phy_i(req_phy_i), .req_reg_i(req_reg_i), .req_wdata_i(req_wdata_i),
        .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // monitor state (each written by one process only)
    int   nb = 0;
    int   base = 0;
    bit   cur_wr = 1'b0;
    logic [15:0] phy_word = '0;
    logic rec_val [0:255];
    logic rec_oe  [0:255];
    int   stab_err = 0;
    int   hi_cyc = 0, busy_cyc = 0, done_cyc = 0, cyc = 0;

    always @(posedge mdc_o) begin
        int k;
        k = nb - base;
        if (k >= 0 && k < 256) begin
            rec_val[k] = mdio_o;
            rec_oe[k]  = mdio_oe_o;
        end
        if (!cur_wr && k >= 49 && k < 65) mdio_i = phy_word[15 - (k - 49)];
        else mdio_i = 1'b1;
        nb = nb + 1;
    end

    always @(negedge mdc_o) begin
        int k;
        k = nb - 1 - base;
        if (k >= 0 && k < 256 && mdio_o !== rec_val[k]) stab_err = stab_err + 1;
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mdc_o)  hi_cyc = hi_cyc + 1;
        if (busy_o) busy_cyc = busy_cyc + 1;
        if (done_o) done_cyc = done_cyc + 1;
    end

    initial begin
        wait (cyc > 190000);
        $display("FAIL watchdog actual=%0d expected<190000 cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad + 1);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] field(input int from, input int len);
        logic [15:0] v = '0;
        for (int j = 0; j < len; j++) v = {v[14:0], rec_val[from + j]};
        return v;
    endfunction

    task automatic do_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] dat, input bit poke);
        int nbits, b_busy, b_hi, b_done, b_stab, wd, ones, oe_bad;
        logic [15:0] got;
        nbits = wr ? 66 : 65;
        base = nb;
        cur_wr = wr;
        phy_word = dat;
        b_busy = busy_cyc; b_hi = hi_cyc; b_done = done_cyc; b_stab = stab_err;
        @(negedge clk);
        req_write_i = wr; req_phy_i = phy; req_reg_i = rg; req_wdata_i = dat; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        wd = 0;
        while (done_cyc == b_done && wd < 5000) begin
            @(negedge clk);
            wd++;
            if (poke && wd == 40) begin
                req_write_i = ~wr; req_phy_i = ~phy; req_reg_i = ~rg;
                req_wdata_i = ~dat; req_i = 1'b1;
            end
            if (poke && wd == 41) req_i = 1'b0;
        end
        check(wd < 5000, "R8 done seen", wd, 5000);
        // R8 done lasts one cycle, busy already low
        check(!busy_o, "R8 busy low at done", busy_o, 0);
        repeat (4) @(negedge clk);
        check(done_cyc - b_done == 1, "R8 done width", done_cyc - b_done, 1);
        // R6 / R4 / R5 bit count and timing
        check(nb - base == nbits, wr ? "R4 bit count" : "R5 bit count", nb - base, nbits);
        check(busy_cyc - b_busy == nbits * 3 * DIV, "R6 busy cycles",
              busy_cyc - b_busy, nbits * 3 * DIV);
        check(hi_cyc - b_hi == nbits * DIV, "R6 clock high cycles", hi_cyc - b_hi, nbits * DIV);
        check(stab_err == b_stab, "R6 data stable in bit", stab_err - b_stab, 0);
        // R1 preamble
        ones = 0;
        for (int j = 0; j < 34; j++) ones += (rec_val[j] === 1'b1) ? 1 : 0;
        check(ones == 34, "R1 preamble ones", ones, 34);
        // R2 start + opcode
        got = field(34, 4);
        check(got == (wr ? 16'h5 : 16'h6), "R2 start/opcode", got, wr ? 5 : 6);
        // R3 addresses
        got = field(38, 10);
        check(got == {6'd0, phy, rg}, "R3 phy/reg address", got, {6'd0, phy, rg});
        // R7 drive enable pattern
        oe_bad = 0;
        for (int j = 0; j < nbits; j++)
            if (rec_oe[j] !== ((wr || j < 48) ? 1'b1 : 1'b0)) oe_bad++;
        check(oe_bad == 0, "R7 drive enable pattern", oe_bad, 0);
        if (wr) begin
            got = field(48, 2);
            check(got == 16'h2, "R4 write turnaround", got, 2);
            got = field(50, 16);
            check(got == dat, "R4 write data", got, dat);
        end else begin
            check(rd_data_o == dat, "R5 read data", rd_data_o, dat);
        end
        check(!mdio_oe_o && !mdc_o, "R7 idle released", {mdio_oe_o, mdc_o}, 0);
        if (poke) begin
            b_busy = busy_cyc;
            repeat (30) @(negedge clk);
            // R9 the mid-frame request did not start another frame
            check(busy_cyc == b_busy && !busy_o, "R9 request while busy ignored",
                  busy_cyc - b_busy, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!busy_o && !done_o && !mdc_o && !mdio_oe_o, "R10 reset outputs",
              {busy_o, done_o, mdc_o, mdio_oe_o}, 0);
        check(rd_data_o == 16'h0, "R10 reset read data", rd_data_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy_o && !mdio_oe_o, "R10 idle after reset", {busy_o, mdio_oe_o}, 0);
        for (int i = 0; i < 32; i++) begin
            do_frame(1'b1, 5'(i), 5'(31 - i), 16'(i * 16'h0F0F + 16'h1234), 1'b0);
            do_frame(1'b0, 5'(31 - i), 5'(i), 16'((i * 16'h1357) ^ 16'h8001), 1'b0);
        end
        do_frame(1'b1, 5'h15, 5'h0A, 16'hFFFF, 1'b1);
        do_frame(1'b0, 5'h00, 5'h1F, 16'h0000, 1'b1);
        do_frame(1'b0, 5'h1F, 5'h00, 16'hFFFF, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule